// File: doc/BRIEF.md
# SD SPI-Mode Command and R1 Response Engine

This block issues one SPI-mode memory-card command and collects the card's answer. It works through a byte-wide transfer port to a separate SPI shifter: it presents a byte and a start strobe, and the shifter later returns the byte it received together with a done strobe. The host supplies the command index, a 32-bit argument, whether four trailing bytes follow the status byte, and whether the card stays selected afterwards. The engine returns the R1 status byte, the trailing word and a timeout flag, and it drives chip select throughout.

The six-byte frame carries a fixed check byte. The check byte is 0x87 for command 8 and 0x95 for every other command, so no CRC logic is needed. After the frame, the engine clocks 0xFF filler bytes until one arrives with its top bit clear, up to a parameterised number of attempts. It can then read a four-byte trailer. Finally it either releases the card and clocks one more filler byte, or it keeps the card selected so that a data phase handled elsewhere can follow.

Top module: `sd_cmd_engine`

## Requirements
- R1: Frame byte 0 is 0x40 OR the 6-bit index. Bytes 1 to 4 are the argument, most significant byte first. Byte 5 is the check byte.
- R2: The check byte is 0x87 when the index is 8 and 0x95 for every other index.
- R3: After the frame the engine sends 0xFF in each polling slot. The first received byte with bit 7 = 0 is returned on `res_r1`, and `res_timeout` is 0.
- R4: If RETRY_LIMIT polling slots all return a byte with bit 7 = 1, the result is `res_timeout` = 1, `res_r1` = 0xFF and `res_trail` = 0. The card is then released and one 0xFF filler byte follows, even in keep-selected mode.
- R5: With `req_trail` = 1, the four bytes received after R1 appear on `res_trail`, the first received in bits 31:24. With `req_trail` = 0, `res_trail` is 0 and no extra slot is used.
- R6: With `req_keep` = 0, `cs_n` goes high after the response and exactly one 0xFF slot is clocked with `cs_n` high before `res_valid`.
- R7: With `req_keep` = 1 and no timeout, `cs_n` is still low at `res_valid` and stays low afterwards, and no filler slot is clocked.
- R8: `cs_n` is low before the first frame byte. `busy` is high from the cycle after acceptance through the `res_valid` cycle, and it is high whenever `xfer_start` is.
- R9: A `req_valid` pulse while `busy` is high is ignored: no slot is added and no second result is produced.
- R10: `res_valid` is a one-cycle pulse. `xfer_start` is never raised again before the previous transfer's `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request strobe, taken only when idle |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_trail | input | 1 | Capture four bytes after R1 |
| req_keep | input | 1 | Keep the card selected after a successful response |
| busy | output | 1 | Command in progress |
| cs_n | output | 1 | Active-low chip select |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_start | output | 1 | Start one byte transfer |
| xfer_rx | input | 8 | Byte shifted in |
| xfer_done | input | 1 | Transfer finished, `xfer_rx` valid |
| res_valid | output | 1 | Result strobe |
| res_r1 | output | 8 | R1 status byte, or 0xFF on timeout |
| res_trail | output | 32 | Trailing bytes, first received in bits 31:24 |
| res_timeout | output | 1 | No response within the retry limit |

## Verification
The bench sweeps every command index. For each one it varies the number of filler bytes before R1 across both sides of a small retry limit, and it crosses this with trailer and keep-selected modes.

- A design with an off-by-one retry count would time out one slot early or accept one slot late. At the limit this shows up as a wrong timeout flag and a wrong slot total.
- A design that compared the index loosely would put 0x87 on the wrong command.
- A design that reversed the trailer's byte order, or held the card selected after a timeout in keep-selected mode, would give wrong result words or a wrong chip-select level at the last slot.
- Each command is followed by a stray request while busy. An engine that accepted it would show extra slots or a second result pulse.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_POLL,
      ST_TRAIL,
      ST_DUMMY,
      ST_DONE
   } sd_cmd_state_e;

   localparam int unsigned FRAME_BYTES = 6;
   localparam logic [7:0]  FILL_BYTE   = 8'hFF;
   localparam logic [1:0]  START_BITS  = 2'b01;

endpackage

// File: rtl/sd_cmd_frame.sv
module sd_cmd_frame #(
   parameter logic [7:0] CRC_DEFAULT = 8'h95,
   parameter logic [7:0] CRC_ALT     = 8'h87,
   parameter int unsigned ALT_INDEX  = 8,
   parameter int unsigned SEL_W      = 3
) (
   input  logic [5:0]       index,
   input  logic [31:0]      arg,
   input  logic [SEL_W-1:0] sel,
   output logic [7:0]       frame_byte
);
   import sd_cmd_pkg::*;

   logic [7:0] crc_byte;

   generate
      if (CRC_ALT == CRC_DEFAULT) begin : g_crc_const
         assign crc_byte = CRC_DEFAULT;
      end else begin : g_crc_sel
         assign crc_byte = (index == 6'(ALT_INDEX)) ? CRC_ALT : CRC_DEFAULT;
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_W'(0): frame_byte = {START_BITS, index};
         SEL_W'(1): frame_byte = arg[31:24];
         SEL_W'(2): frame_byte = arg[23:16];
         SEL_W'(3): frame_byte = arg[15:8];
         SEL_W'(4): frame_byte = arg[7:0];
         SEL_W'(5): frame_byte = crc_byte;
         default:   frame_byte = FILL_BYTE;
      endcase
   end
endmodule

// File: rtl/sd_cmd_retry.sv
module sd_cmd_retry #(
   parameter int unsigned LIMIT = 5000,
   localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   logic [CW-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (step) begin
         count_q <= count_q + CW'(1);
      end
   end

   assign last = (count_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sd_cmd_trail.sv
module sd_cmd_trail #(
   parameter int unsigned NBYTES = 4,
   localparam int unsigned W     = NBYTES * 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift,
   input  logic [7:0]   din,
   output logic [W-1:0] data
);
   logic [W-1:0] data_q;

   generate
      if (NBYTES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      data_q <= '0;
            else if (clear)  data_q <= '0;
            else if (shift)  data_q <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      data_q <= '0;
            else if (clear)  data_q <= '0;
            else if (shift)  data_q <= {data_q[W-9:0], din};
         end
      end
   endgenerate

   assign data = data_q;
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
   parameter int unsigned RETRY_LIMIT = 5000,
   parameter int unsigned TRAIL_BYTES = 4,
   parameter logic [7:0]  CRC_DEFAULT = 8'h95,
   parameter logic [7:0]  CRC_ALT     = 8'h87,
   parameter int unsigned ALT_INDEX   = 8,
   localparam int unsigned TRAIL_W    = TRAIL_BYTES * 8,
   localparam int unsigned CNT_MAX    = (TRAIL_BYTES > 6) ? TRAIL_BYTES : 6,
   localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [5:0]         req_index,
   input  logic [31:0]        req_arg,
   input  logic               req_trail,
   input  logic               req_keep,
   output logic               busy,
   output logic               cs_n,
   output logic [7:0]         xfer_tx,
   output logic               xfer_start,
   input  logic [7:0]         xfer_rx,
   input  logic               xfer_done,
   output logic               res_valid,
   output logic [7:0]         res_r1,
   output logic [TRAIL_W-1:0] res_trail,
   output logic               res_timeout
);
   import sd_cmd_pkg::*;

   generate
      if (RETRY_LIMIT < 2) begin : g_bad_limit
         $error("RETRY_LIMIT must be at least 2");
      end
      if (TRAIL_BYTES < 1) begin : g_bad_trail
         $error("TRAIL_BYTES must be at least 1");
      end
      if (ALT_INDEX > 63) begin : g_bad_index
         $error("ALT_INDEX must fit in six bits");
      end
   endgenerate

   sd_cmd_state_e st_q;
   logic [5:0]    index_q;
   logic [31:0]   arg_q;
   logic          trail_q;
   logic          keep_q;
   logic          wait_q;
   logic [CNT_W-1:0] cnt_q;
   logic          cs_n_q;
   logic          start_q;
   logic [7:0]    tx_q;
   logic          valid_q;
   logic [7:0]    r1_q;
   logic          tout_q;

   logic [7:0]    frame_byte;
   logic          retry_last;
   logic          byte_back;
   logic          resp_found;

   assign byte_back  = wait_q && xfer_done;
   assign resp_found = !xfer_rx[7];

   sd_cmd_frame #(
      .CRC_DEFAULT (CRC_DEFAULT),
      .CRC_ALT     (CRC_ALT),
      .ALT_INDEX   (ALT_INDEX),
      .SEL_W       (CNT_W)
   ) frame_i (
      .index      (index_q),
      .arg        (arg_q),
      .sel        (cnt_q),
      .frame_byte (frame_byte)
   );

   sd_cmd_retry #(
      .LIMIT (RETRY_LIMIT)
   ) retry_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st_q == ST_SEND),
      .step  ((st_q == ST_POLL) && byte_back && !resp_found),
      .last  (retry_last)
   );

   sd_cmd_trail #(
      .NBYTES (TRAIL_BYTES)
   ) trail_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st_q == ST_SEND),
      .shift ((st_q == ST_TRAIL) && byte_back),
      .din   (xfer_rx),
      .data  (res_trail)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         index_q <= '0;
         arg_q   <= '0;
         trail_q <= 1'b0;
         keep_q  <= 1'b0;
         wait_q  <= 1'b0;
         cnt_q   <= '0;
         cs_n_q  <= 1'b1;
         start_q <= 1'b0;
         tx_q    <= FILL_BYTE;
         valid_q <= 1'b0;
         r1_q    <= '0;
         tout_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         valid_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  index_q <= req_index;
                  arg_q   <= req_arg;
                  trail_q <= req_trail;
                  keep_q  <= req_keep;
                  cs_n_q  <= 1'b0;
                  cnt_q   <= '0;
                  wait_q  <= 1'b0;
                  tout_q  <= 1'b0;
                  r1_q    <= '0;
                  st_q    <= ST_SEND;
               end
            end
            ST_SEND, ST_POLL, ST_TRAIL, ST_DUMMY: begin
               if (!wait_q) begin
                  start_q <= 1'b1;
                  tx_q    <= (st_q == ST_SEND) ? frame_byte : FILL_BYTE;
                  wait_q  <= 1'b1;
               end else if (xfer_done) begin
                  wait_q <= 1'b0;
                  case (st_q)
                     ST_SEND: begin
                        if (cnt_q == CNT_W'(FRAME_BYTES - 1)) begin
                           cnt_q <= '0;
                           st_q  <= ST_POLL;
                        end else begin
                           cnt_q <= cnt_q + CNT_W'(1);
                        end
                     end
                     ST_POLL: begin
                        if (resp_found) begin
                           r1_q <= xfer_rx;
                           if (trail_q) begin
                              cnt_q <= '0;
                              st_q  <= ST_TRAIL;
                           end else if (keep_q) begin
                              valid_q <= 1'b1;
                              st_q    <= ST_DONE;
                           end else begin
                              cs_n_q <= 1'b1;
                              st_q   <= ST_DUMMY;
                           end
                        end else if (retry_last) begin
                           r1_q   <= FILL_BYTE;
                           tout_q <= 1'b1;
                           cs_n_q <= 1'b1;
                           st_q   <= ST_DUMMY;
                        end
                     end
                     ST_TRAIL: begin
                        if (cnt_q == CNT_W'(TRAIL_BYTES - 1)) begin
                           if (keep_q) begin
                              valid_q <= 1'b1;
                              st_q    <= ST_DONE;
                           end else begin
                              cs_n_q <= 1'b1;
                              st_q   <= ST_DUMMY;
                           end
                        end else begin
                           cnt_q <= cnt_q + CNT_W'(1);
                        end
                     end
                     default: begin
                        valid_q <= 1'b1;
                        st_q    <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_DONE: begin
               st_q <= ST_IDLE;
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign cs_n        = cs_n_q;
   assign xfer_tx     = tx_q;
   assign xfer_start  = start_q;
   assign res_valid   = valid_q;
   assign res_r1      = r1_q;
   assign res_timeout = tout_q;
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk #(
   parameter int unsigned TRAIL_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               busy,
   input logic               cs_n,
   input logic               xfer_start,
   input logic               xfer_done,
   input logic               res_valid,
   input logic [7:0]         res_r1,
   input logic [TRAIL_W-1:0] res_trail,
   input logic               res_timeout
);
   logic outstanding_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          outstanding_q <= 1'b0;
      else if (xfer_start) outstanding_q <= 1'b1;
      else if (xfer_done)  outstanding_q <= 1'b0;
   end

   // R10
   single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> !outstanding_q);

   // R10
   result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R8
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> busy);

   // R8
   result_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> busy);

   // R8
   accept_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !cs_n && $past(req_valid));

   // R3
   r1_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_timeout) |-> !res_r1[7]);

   // R4
   timeout_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_timeout) |-> (res_r1 == 8'hFF) && cs_n && (res_trail == '0));

   // R9
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !res_valid) |=> busy);
endmodule

bind sd_cmd_engine sd_cmd_engine_chk #(.TRAIL_W(TRAIL_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .busy        (busy),
   .cs_n        (cs_n),
   .xfer_start  (xfer_start),
   .xfer_done   (xfer_done),
   .res_valid   (res_valid),
   .res_r1      (res_r1),
   .res_trail   (res_trail),
   .res_timeout (res_timeout)
);

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb_top;
   localparam int LIMIT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_index = '0;
   logic [31:0] req_arg = '0;
   logic        req_trail = 1'b0;
   logic        req_keep = 1'b0;
   logic        busy, cs_n, xfer_start, res_valid, res_timeout;
   logic [7:0]  xfer_tx, res_r1;
   logic [31:0] res_trail;
   logic [7:0]  xfer_rx = 8'hFF;
   logic        xfer_done = 1'b0;

   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   sd_cmd_engine #(.RETRY_LIMIT(LIMIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
      .req_arg(req_arg), .req_trail(req_trail), .req_keep(req_keep),
      .busy(busy), .cs_n(cs_n), .xfer_tx(xfer_tx), .xfer_start(xfer_start),
      .xfer_rx(xfer_rx), .xfer_done(xfer_done), .res_valid(res_valid),
      .res_r1(res_r1), .res_trail(res_trail), .res_timeout(res_timeout));

   // card model state
   logic       clr_log = 1'b0;
   int         slot = 0;
   int         lat = 0;
   logic [7:0] pend = 8'hFF;
   logic [7:0] tx_log [0:31];
   logic       cs_log [0:31];
   int         m_wait = 0;
   logic [7:0] m_r1 = 8'h00;
   logic [7:0] m_tr [0:3];
   int         vcount = 0;

   function automatic logic [7:0] card_byte(int s);
      int p;
      p = s - 6;
      if (p < 0) return 8'hFF;
      if (p < m_wait) return 8'h80 | 8'(s);
      if (p == m_wait) return m_r1;
      if (p - m_wait - 1 < 4) return m_tr[p - m_wait - 1];
      return 8'hFF;
   endfunction

   always @(posedge clk) begin
      xfer_done <= 1'b0;
      if (res_valid) vcount <= vcount + 1;
      if (clr_log) begin
         slot <= 0;
         vcount <= 0;
      end else if (xfer_start) begin
         if (slot < 32) begin
            tx_log[slot] <= xfer_tx;
            cs_log[slot] <= cs_n;
         end
         pend <= card_byte(slot);
         slot <= slot + 1;
         lat  <= 2;
      end else if (lat == 1) begin
         xfer_done <= 1'b1;
         xfer_rx   <= pend;
         lat       <= 0;
      end else if (lat > 1) begin
         lat <= lat - 1;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run(input int idx, input int nwait, input bit trl, input bit keep);
      logic [31:0] arg;
      logic [31:0] exp_tr;
      bit          tout;
      int          exp_slots;
      int          guard;
      logic [7:0]  crc;
      bit          poll_ok;
      arg  = 32'h1234_5678 ^ (32'(idx) * 32'h0101_0307);
      tout = (nwait >= LIMIT);
      @(negedge clk);
      m_wait = nwait;
      m_r1   = {1'b0, 7'(idx * 5 + 1)};
      for (int k = 0; k < 4; k++) m_tr[k] = 8'(idx * 17 + k * 29 + 3);
      clr_log = 1'b1;
      @(negedge clk);
      clr_log   = 1'b0;
      req_index = 6'(idx);
      req_arg   = arg;
      req_trail = trl;
      req_keep  = keep;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      // R8: selected and busy once accepted
      check(busy && !cs_n, "R8 busy/cs after accept", {busy, cs_n}, 2'b10);
      repeat (6) @(negedge clk);
      // R9: stray request while busy
      req_index = 6'(idx + 1);
      req_arg   = ~arg;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!res_valid && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      check(res_valid, "R10 result strobe seen", res_valid, 1);
      exp_tr = trl && !tout ? {m_tr[0], m_tr[1], m_tr[2], m_tr[3]} : 32'h0;
      if (tout) begin
         check(res_timeout && res_r1 == 8'hFF, "R4 timeout result",
               {res_timeout, res_r1}, 9'h1FF);
         check(res_trail == 0, "R4 trail cleared on timeout", res_trail, 0);
      end else begin
         check(!res_timeout && res_r1 == m_r1, "R3 r1 value",
               {res_timeout, res_r1}, {1'b0, m_r1});
         check(res_trail == exp_tr, "R5 trailing bytes", res_trail, exp_tr);
      end
      check(busy, "R8 busy at result", busy, 1);
      @(negedge clk);
      check(!res_valid && !busy, "R10 result single pulse",
            {res_valid, busy}, 2'b00);
      repeat (20) @(negedge clk);
      // frame
      crc = (idx == 8) ? 8'h87 : 8'h95;
      check(tx_log[0] == (8'h40 | 8'(idx)) && tx_log[1] == arg[31:24] &&
            tx_log[2] == arg[23:16] && tx_log[3] == arg[15:8] &&
            tx_log[4] == arg[7:0], "R1 frame bytes",
            {tx_log[0], tx_log[1], tx_log[2], tx_log[3], tx_log[4]},
            {8'h40 | 8'(idx), arg});
      check(tx_log[5] == crc, "R2 check byte", tx_log[5], crc);
      if (tout)      exp_slots = 6 + LIMIT + 1;
      else           exp_slots = 6 + nwait + 1 + (trl ? 4 : 0) + (keep ? 0 : 1);
      check(slot == exp_slots && vcount == 1, "R9 slot and result count",
            {slot[15:0], vcount[15:0]}, {exp_slots[15:0], 16'd1});
      poll_ok = 1'b1;
      for (int s = 6; s < exp_slots && s < 32; s++)
         if (tx_log[s] !== 8'hFF) poll_ok = 1'b0;
      check(poll_ok, "R3 filler bytes after frame", poll_ok, 1);
      if (keep && !tout) begin
         check(!cs_n && !cs_log[exp_slots - 1], "R7 card kept selected",
               {cs_n, cs_log[exp_slots - 1]}, 2'b00);
      end else begin
         check(cs_n && cs_log[exp_slots - 1] && !cs_log[exp_slots - 2],
               "R6 single filler slot after release",
               {cs_n, cs_log[exp_slots - 1], cs_log[exp_slots - 2]}, 3'b110);
      end
      check(!cs_log[0], "R8 selected before first byte", cs_log[0], 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n && !busy && !xfer_start && !res_valid, "R8 reset state",
            {cs_n, busy, xfer_start, res_valid}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      for (int idx = 0; idx < 64; idx++)
         run(idx, idx % 10, idx[1], idx[2]);
      // boundary: limit exactly, keep mode
      run(8, LIMIT - 1, 1'b1, 1'b1);
      run(8, LIMIT, 1'b1, 1'b1);
      run(9, LIMIT + 1, 1'b0, 1'b0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule